// File: doc/BRIEF.md
# Fetch/Gather Transfer Sequencer

This block walks a short list of transfer instructions and moves data between a twelve-bank data memory and a pipelined compute array. It understands two kinds of transfer. A fetch copies one word from every bank into a wide input register that feeds the array. A gather writes the array's output register back to the banks. Each transfer carries a bank address and a transfer-table index, and the block hands both on to the permutation network that lies between the banks and the array. A third instruction kind ends the list.

The array has seven inter-row pipeline registers, and each one is enabled on its own. The number of cycles a result takes to cross the array is one more than the number of enabled stages, because the output register adds one capture cycle. Every fetch restarts a countdown at that latency. A gather waits, with a stall flag raised, until the countdown has drained, so it never writes back an incomplete result. A fetch never waits.

The stage-enable vector is sampled only while the block is idle. The latency therefore stays fixed for the whole of one pass through the list.

Top module: `xfer_seq`

## Requirements
- R1: After reset, fetchEn, gatherEn, stall and done are low, instrAddr is 0 and every bit of arrayIn is 0.
- R2: Instruction encoding, 14 bits: bits [13:12] are the opcode (0 fetch, 1 gather, 2 halt, 3 also halt), bits [11:4] are the bank address and bits [3:0] are the table index. Execution starts at instruction address 0 on the cycle after start is seen high while idle.
- R3: A fetch raises fetchEn in the same cycle its instruction is presented, never raises stall, and on the next cycle arrayIn holds the 12 bank words that were present on bankRdData during the fetch.
- R4: While fetchEn or gatherEn is high, bankAddr and tableSel carry that instruction's address and table fields.
- R5: The array latency L is 1 plus the number of set bits in the sampled stage-enable vector. A gather presented directly after a fetch keeps stall high for exactly L cycles, and gatherEn rises L+1 cycles after the fetch.
- R6: Each fetch reloads the countdown with L, so the most recent fetch governs the wait of a following gather.
- R7: A gather that finds the countdown already drained, including one with no earlier fetch in the run, issues at once with no stall.
- R8: While stall is high, instrAddr does not advance and neither fetchEn nor gatherEn is high.
- R9: stageEn is sampled only while idle. A change made during a run does not alter that run's gather wait, and it takes effect at the next start.
- R10: A halt opcode (2 or 3) raises done on the next cycle and returns the block to idle. While done is high, no strobe or stall is raised, and done clears when the next run starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run from instruction 0 when idle |
| stageEn | input | 7 | Per-stage pipeline enable of the array |
| instrAddr | output | 6 | Address into the instruction store |
| instrData | input | 14 | Instruction word at instrAddr, same cycle |
| bankAddr | output | 8 | Row address for all banks during a transfer |
| tableSel | output | 4 | Transfer-table index for the permutation network |
| fetchEn | output | 1 | Fetch transfer in this cycle |
| gatherEn | output | 1 | Gather write-back in this cycle |
| stall | output | 1 | Gather is waiting for the array result |
| bankRdData | input | 192 | Twelve 16-bit bank read words, bank 0 lowest |
| arrayIn | output | 192 | Input register feeding the array |
| done | output | 1 | Last run ended on a halt |

## Verification
Assertions placed beside the logic check the cycle-level rules on every clock edge. They check the reload of the countdown on a fetch and its step-down by one, the capture of the bank words into the input register, the frozen instruction address and mutual exclusion of strobes during a stall, and the quiet state once a halt is reached. The exact gather timing for several stage vectors, the dominance of the latest fetch, the immediate gather with no pending result, and the fact that a mid-run change of stageEn has no effect can only be shown by the bench's directed programs. The bench checks these by counting cycles from the fetch.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int BANKS   = 12;
  localparam int DATA_W  = 16;
  localparam int STAGES  = 7;
  localparam int ADDR_W  = 8;
  localparam int TBL_W   = 4;
  localparam int PC_W    = 6;
  localparam int OP_W    = 2;
  localparam int INSTR_W = OP_W + ADDR_W + TBL_W;
  localparam int BUS_W   = BANKS * DATA_W;
  localparam int LAT_W   = $clog2(STAGES + 2);

  typedef enum logic [OP_W-1:0] {
    OP_FETCH  = 2'd0,
    OP_GATHER = 2'd1,
    OP_HALT   = 2'd2,
    OP_STOP   = 2'd3
  } xferOp_t;

  typedef enum logic {S_IDLE = 1'b0, S_RUN = 1'b1} seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic fetch;
    logic gather;
    logic loadCfg;
    logic clrCnt;
  } xferStrb_t;
endpackage

// File: rtl/seq_dp.sv
module seq_dp
  import xfer_pkg::*;
#(
  parameter int NBANK = BANKS,
  parameter int WORDW = DATA_W,
  parameter int NSTG  = STAGES,
  parameter int LATW  = LAT_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  xferStrb_t              strb,
  input  logic [NSTG-1:0]        stageEn,
  input  logic [NBANK*WORDW-1:0] bankRdData,
  output logic [NBANK*WORDW-1:0] arrayIn,
  output logic                   cntZero
);
  localparam int BW = NBANK * WORDW;

  logic [NSTG-1:0] cfgReg;
  logic [LATW-1:0] lat;
  logic [LATW-1:0] cnt;
  logic [BW-1:0]   fetchReg;

  // stage snapshot, refreshed only while idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cfgReg <= '0;
    else if (strb.loadCfg) cfgReg <= stageEn;
  end

  // latency: capture cycle plus one per enabled stage
  always_comb begin
    lat = LATW'(1);
    for (int i = 0; i < NSTG; i++) lat = lat + LATW'(cfgReg[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (strb.clrCnt)   cnt <= '0;
    else if (strb.fetch)    cnt <= lat;
    else if (cnt != '0)     cnt <= cnt - LATW'(1);
  end

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           fetchReg <= '0;
    else if (strb.fetch) fetchReg <= bankRdData;
  end

  assign arrayIn = fetchReg;

  p_cnt_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.fetch |=> cnt == $past(lat));

  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != '0 && !strb.fetch && !strb.clrCnt) |=> cnt == $past(cnt) - LATW'(1));

  p_gather_drained_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.gather |=> cnt == '0);

  p_capture_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.fetch |=> arrayIn == $past(bankRdData));
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import xfer_pkg::*;
#(
  parameter int PCW  = PC_W,
  parameter int ADRW = ADDR_W,
  parameter int TBLW = TBL_W,
  parameter int OPW  = OP_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic [OPW+ADRW+TBLW-1:0]  instrData,
  input  logic                      cntZero,
  output logic [PCW-1:0]            instrAddr,
  output xferStrb_t                 strb,
  output logic [ADRW-1:0]           bankAddr,
  output logic [TBLW-1:0]           tableSel,
  output logic                      stall,
  output logic                      done
);
  localparam int IW = OPW + ADRW + TBLW;

  seqState_t      state;
  logic [PCW-1:0] pc;
  logic           haltNow;
  xferOp_t        op;
  logic [ADRW-1:0] fAddr;
  logic [TBLW-1:0] fTbl;

  assign op    = xferOp_t'(instrData[IW-1 -: OPW]);
  assign fAddr = instrData[TBLW +: ADRW];
  assign fTbl  = instrData[TBLW-1:0];

  always_comb begin
    strb    = '0;
    stall   = 1'b0;
    haltNow = 1'b0;
    if (state == S_IDLE) begin
      strb.loadCfg = 1'b1;
      strb.clrCnt  = start;
    end else begin
      case (op)
        OP_FETCH:  strb.fetch = 1'b1;
        OP_GATHER: begin
          if (cntZero) strb.gather = 1'b1;
          else         stall       = 1'b1;
        end
        default:   haltNow = 1'b1;
      endcase
    end
  end

  assign bankAddr  = (strb.fetch || strb.gather) ? fAddr : '0;
  assign tableSel  = (strb.fetch || strb.gather) ? fTbl  : '0;
  assign instrAddr = pc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      pc    <= '0;
      done  <= 1'b0;
    end else if (state == S_IDLE) begin
      if (start) begin
        state <= S_RUN;
        pc    <= '0;
        done  <= 1'b0;
      end
    end else if (haltNow) begin
      state <= S_IDLE;
      done  <= 1'b1;
    end else if (strb.fetch || strb.gather) begin
      pc <= pc + PCW'(1);
    end
  end

  p_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.fetch, strb.gather, stall}));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> $stable(instrAddr));

  p_fetch_adv_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.fetch |=> instrAddr == $past(instrAddr) + PCW'(1));

  p_halt_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    haltNow |=> done && state == S_IDLE);

  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !strb.fetch && !strb.gather && !stall);
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xfer_pkg::*;
#(
  parameter int NBANK = BANKS,
  parameter int WORDW = DATA_W,
  parameter int NSTG  = STAGES,
  parameter int ADRW  = ADDR_W,
  parameter int TBLW  = TBL_W,
  parameter int PCW   = PC_W
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         start,
  input  logic [NSTG-1:0]              stageEn,
  output logic [PCW-1:0]               instrAddr,
  input  logic [OP_W+ADRW+TBLW-1:0]    instrData,
  output logic [ADRW-1:0]              bankAddr,
  output logic [TBLW-1:0]              tableSel,
  output logic                         fetchEn,
  output logic                         gatherEn,
  output logic                         stall,
  input  logic [NBANK*WORDW-1:0]       bankRdData,
  output logic [NBANK*WORDW-1:0]       arrayIn,
  output logic                         done
);
  localparam int LATW = $clog2(NSTG + 2);

  xferStrb_t strb;
  logic      cntZero;

  seq_ctrl #(.PCW(PCW), .ADRW(ADRW), .TBLW(TBLW), .OPW(OP_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .instrData(instrData),
    .cntZero(cntZero), .instrAddr(instrAddr), .strb(strb),
    .bankAddr(bankAddr), .tableSel(tableSel), .stall(stall), .done(done)
  );

  seq_dp #(.NBANK(NBANK), .WORDW(WORDW), .NSTG(NSTG), .LATW(LATW)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .stageEn(stageEn),
    .bankRdData(bankRdData), .arrayIn(arrayIn), .cntZero(cntZero)
  );

  assign fetchEn  = strb.fetch;
  assign gatherEn = strb.gather;
endmodule

// File: tb/sim_xfer_seq.sv
module sim_xfer_seq;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [6:0]   stageEn = '0;
  logic [5:0]   instrAddr;
  logic [13:0]  instrData;
  logic [7:0]   bankAddr;
  logic [3:0]   tableSel;
  logic         fetchEn, gatherEn, stall, done;
  logic [191:0] bankRdData;
  logic [191:0] arrayIn;

  logic [13:0] prog [64];

  int nChk = 0;
  int nBad = 0;

  // results of the last run
  int fAt[8];
  int gAt[8];
  int nF, nG, nStall, pcMoved, mixBad, doneAtC0, runLen;
  logic [7:0] fAddrSeen;
  logic [3:0] fTblSeen;

  always #4 clk = ~clk;

  assign instrData = prog[instrAddr];

  always_comb begin
    for (int k = 0; k < 12; k++) bankRdData[k*16 +: 16] = {bankAddr, 8'(k)};
  end

  xfer_seq u0 (
    .clk(clk), .rstN(rstN), .start(start), .stageEn(stageEn),
    .instrAddr(instrAddr), .instrData(instrData), .bankAddr(bankAddr),
    .tableSel(tableSel), .fetchEn(fetchEn), .gatherEn(gatherEn),
    .stall(stall), .bankRdData(bankRdData), .arrayIn(arrayIn), .done(done)
  );

  function automatic logic [13:0] enc(input int op, input int adr, input int tbl);
    return {2'(op), 8'(adr), 4'(tbl)};
  endfunction

  function automatic int latOf(input logic [6:0] s);
    return 1 + $countones(s);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  task automatic clearProg();
    for (int i = 0; i < 64; i++) prog[i] = enc(2, 0, 0);
  endtask

  // start a run with s0 sampled, switch stageEn to s1 during the run
  task automatic execRun(input logic [6:0] s0, input logic [6:0] s1);
    int c;
    logic prevStall;
    logic [5:0] prevAddr;
    nF = 0; nG = 0; nStall = 0; pcMoved = 0; mixBad = 0;
    prevStall = 1'b0; prevAddr = '0;
    @(negedge clk);
    start = 1'b1; stageEn = s0;
    @(negedge clk);
    start = 1'b0; stageEn = s1;
    doneAtC0 = int'(done);
    c = 0;
    while (!(done && c > 0) && c < 300) begin
      if (prevStall && instrAddr != prevAddr) pcMoved++;
      if (stall && (fetchEn || gatherEn)) mixBad++;
      if (fetchEn) begin
        if (nF == 0) begin fAddrSeen = bankAddr; fTblSeen = tableSel; end
        if (nF < 8) fAt[nF] = c;
        nF++;
      end
      if (gatherEn) begin
        if (nG < 8) gAt[nG] = c;
        nG++;
      end
      if (stall) nStall++;
      prevStall = stall;
      prevAddr  = instrAddr;
      c++;
      @(negedge clk);
    end
    runLen = c;
    if (c >= 300) chk("run ends on halt", 0, 1);
  endtask

  task automatic tReset();
    chk("R1 fetchEn", fetchEn, 0);
    chk("R1 gatherEn", gatherEn, 0);
    chk("R1 stall", stall, 0);
    chk("R1 done", done, 0);
    chk("R1 instrAddr", instrAddr, 0);
    chk("R1 arrayIn", (arrayIn == '0), 1);
  endtask

  task automatic tFetch();
    logic ok;
    clearProg();
    prog[0] = enc(0, 8'h5A, 9);
    execRun(7'h00, 7'h00);
    chk("R3 fetch at c0", fAt[0], 0);
    chk("R3 fetch count", nF, 1);
    chk("R3 no stall", nStall, 0);
    chk("R4 bankAddr", fAddrSeen, 8'h5A);
    chk("R4 tableSel", fTblSeen, 9);
    ok = 1'b1;
    for (int k = 0; k < 12; k++)
      if (arrayIn[k*16 +: 16] != {8'h5A, 8'(k)}) ok = 1'b0;
    chk("R3 arrayIn words", ok, 1);
    chk("R2 halt after one fetch", runLen, 2);
  endtask

  task automatic tLatency(input logic [6:0] s);
    int l;
    l = latOf(s);
    clearProg();
    prog[0] = enc(0, 3, 1);
    prog[1] = enc(1, 4, 2);
    execRun(s, s);
    chk("R5 gather cycle", gAt[0], 1 + l);
    chk("R5 stall cycles", nStall, l);
    chk("R8 pc frozen in stall", pcMoved, 0);
    chk("R8 no strobe in stall", mixBad, 0);
  endtask

  task automatic tReload();
    clearProg();
    prog[0] = enc(0, 1, 0);
    prog[1] = enc(0, 2, 0);
    prog[2] = enc(1, 3, 0);
    execRun(7'h03, 7'h03);
    chk("R6 latest fetch governs gather", gAt[0], 2 + 3);
    chk("R6 stall cycles", nStall, 3);
    clearProg();
    prog[0] = enc(0, 1, 0);
    prog[1] = enc(1, 2, 0);
    prog[2] = enc(1, 3, 0);
    execRun(7'h03, 7'h03);
    chk("R7 second gather immediate", gAt[1], 2 + 3);
    chk("R7 stalls only first", nStall, 3);
  endtask

  task automatic tNoFetch();
    clearProg();
    prog[0] = enc(1, 7, 3);
    execRun(7'h7F, 7'h7F);
    chk("R7 gather without fetch", gAt[0], 0);
    chk("R7 no stall", nStall, 0);
  endtask

  task automatic tCfgFreeze();
    clearProg();
    prog[0] = enc(0, 1, 0);
    prog[1] = enc(1, 1, 0);
    execRun(7'h01, 7'h7F);
    chk("R9 midrun change ignored", gAt[0], 3);
    chk("R9 stall uses old latency", nStall, 2);
    execRun(7'h7F, 7'h7F);
    chk("R9 new vector at next start", gAt[0], 9);
  endtask

  task automatic tHalt();
    logic [5:0] a;
    clearProg();
    prog[0] = enc(0, 1, 0);
    prog[1] = enc(3, 0, 0);
    prog[2] = enc(0, 2, 0);
    execRun(7'h00, 7'h00);
    chk("R10 opcode 3 halts", nF, 1);
    chk("R10 done", done, 1);
    a = instrAddr;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 quiet after halt", {fetchEn, gatherEn, stall}, 0);
      chk("R10 done held", done, 1);
      chk("R10 addr held", instrAddr, a);
    end
    clearProg();
    prog[0] = enc(1, 0, 0);
    execRun(7'h00, 7'h00);
    chk("R10 done cleared on start", doneAtC0, 0);
  endtask

  initial begin
    clearProg();
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tFetch();
    tLatency(7'h00);
    tLatency(7'h01);
    tLatency(7'h55);
    tLatency(7'h7F);
    tReload();
    tNoFetch();
    tCfgFreeze();
    tHalt();
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule